// File: doc/BRIEF.md
# Partial Bitstream Loader

This block sits in the static part of a reconfigurable device and moves a partial configuration image from a fast host data channel into the device's byte-wide internal configuration port. The host first writes the image length in bytes. That write is the load request. The host then streams the image bytes. The bytes land in a dual-clock buffer whose write side runs on the host clock and whose read side runs on the slower configuration clock. On the configuration side, a driver pops one byte per configuration clock at most and presents it with chip-enable and write-enable. It pauses whenever the port reports busy.

A single sequencing state machine in the host domain runs both halves of the job. It accepts the image bytes, and it releases the buffer-to-port path only once the host's application input-data transfer has finished. Configuration can therefore overlap computation or output transfer, but never input transfer. The host may keep writing image bytes while the port is already draining them, so an image much longer than the buffer still goes through. The block counts bytes itself and finishes after exactly the requested number. It never looks at any configuration-done indication from the device. A request that arrives during a load is flagged as an error and has no effect on the running load.

Top module: `bitload_ctrl`

## Requirements
- R1: After reset, cfg_en, cfg_wr, h_busy, h_ready, h_done and h_err are all low and the buffer is empty. The first byte presented after reset is the first byte accepted after reset.
- R2: A high h_len_we while h_busy is low starts a load of h_len bytes. h_busy is high from the next host clock until after h_done. h_ready is high only during a load, and only while fewer than h_len bytes have been accepted. A byte is accepted on a host clock edge where h_valid and h_ready are both high.
- R3: During a load the port receives exactly the requested number of bytes, in the order they were accepted. Each byte is on cfg_data for one configuration clock with cfg_en and cfg_wr both high. On every other cycle both enables are low.
- R4: While h_in_active is high (host input-data transfer in progress), no byte is presented to the port. Once h_in_active has been seen low during a load, draining stays enabled for the rest of that load.
- R5: Host bytes continue to be accepted while the port is draining earlier bytes of the same load.
- R6: If cfg_busy is high at a configuration clock edge, cfg_en and cfg_wr are low after that edge.
- R7: When the buffer is full, h_ready drops and no byte is lost or overwritten, so loads longer than the buffer complete correctly.
- R8: h_done is a one-cycle pulse, raised exactly once per load and only after the last byte has been presented. Completion depends only on the byte count. The block has no configuration-done input.
- R9: A high h_len_we while h_busy is high gives a one-cycle h_err pulse on the next host clock. The running load keeps its original length and data.
- R10: Any length from 0 up to 2^LEN_W-1 is accepted. A zero-length load presents no byte and still ends with h_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host-interface clock |
| h_rst_n | input | 1 | Active-low asynchronous reset, host domain |
| h_len_we | input | 1 | Length write; starts a load when idle |
| h_len | input | LEN_W | Image length in bytes |
| h_in_active | input | 1 | High while the host input-data transfer is running |
| h_valid | input | 1 | Image byte valid |
| h_data | input | DATA_W | Image byte |
| h_ready | output | 1 | Block can accept an image byte |
| h_busy | output | 1 | A load is in progress |
| h_done | output | 1 | One-cycle pulse at load completion |
| h_err | output | 1 | One-cycle pulse for a request made while busy |
| c_clk | input | 1 | Configuration clock |
| c_rst_n | input | 1 | Active-low asynchronous reset, configuration domain |
| cfg_busy | input | 1 | Configuration port cannot take a byte |
| cfg_en | output | 1 | Configuration port chip-enable |
| cfg_wr | output | 1 | Configuration port write-enable |
| cfg_data | output | DATA_W | Configuration port byte |

## Verification
Properties that hold on every cycle are checked continuously. These are: the pause after a busy port cycle, buffer writes never hitting a full buffer and reads never hitting an empty one, the error pulse after a request made while busy, the single-cycle width of the done pulse, the latched length staying fixed during a load, and ready staying low while idle. Some behaviours need whole scenarios, and only the bench's loads can show them. These are: exact byte order and count at the port, hold-off while the input transfer is active, overlap of host writes with draining, completion of images longer than the buffer and of an empty image, and a rejected request leaving the running load intact.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_HOLD  = 2'd1,
      LD_RUN   = 2'd2,
      LD_CLEAR = 2'd3
   } ld_state_t;

endpackage

// File: rtl/bitload_sync.sv
module bitload_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bitload_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bitload_fifo.sv
module bitload_fifo #(
   parameter int DW   = 8,
   parameter int AW   = 4,
   parameter int SYNC = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          full,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic          empty
);

   localparam int DEPTH = 1 << AW;

   if (AW < 2) begin : g_bad_aw
      $error("bitload_fifo: AW must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wbin, wbin_nx, wgray, rbin, rbin_nx, rgray;
   logic [AW:0]   rgray_w, wgray_r;

   assign wbin_nx = wbin + 1'b1;
   assign rbin_nx = rbin + 1'b1;

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr) mem[wbin[AW-1:0]] <= wdata;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   bitload_sync #(.W(AW+1), .STAGES(SYNC)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

   bitload_sync #(.W(AW+1), .STAGES(SYNC)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

   assign full  = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
   assign empty = (rgray == wgray_r);
   assign rdata = mem[rbin[AW-1:0]];

endmodule

// File: rtl/bitload_host_fsm.sv
module bitload_host_fsm
   import bitload_pkg::*;
#(
   parameter int LEN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic [LEN_W-1:0] len_in,
   input  logic             in_active,
   input  logic             valid,
   input  logic             full,
   input  logic             fin_async,
   output logic             ready,
   output logic             wr,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             drain_en,
   output logic [LEN_W-1:0] len_q
);

   ld_state_t        state, nxt;
   logic [LEN_W-1:0] wcnt;
   logic             fin_s;

   bitload_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fin (
      .clk(clk), .rst_n(rst_n), .d(fin_async), .q(fin_s));

   always_comb begin
      nxt = state;
      case (state)
         LD_IDLE:  if (len_we)     nxt = in_active ? LD_HOLD : LD_RUN;
         LD_HOLD:  if (!in_active) nxt = LD_RUN;
         LD_RUN:   if (fin_s)      nxt = LD_CLEAR;
         LD_CLEAR: if (!fin_s)     nxt = LD_IDLE;
         default:                  nxt = LD_IDLE;
      endcase
   end

   assign busy  = (state != LD_IDLE);
   assign ready = ((state == LD_HOLD) || (state == LD_RUN)) &&
                  (wcnt != len_q) && !full;
   assign wr    = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LD_IDLE;
         len_q    <= '0;
         wcnt     <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         drain_en <= 1'b0;
      end else begin
         state    <= nxt;
         drain_en <= (nxt == LD_RUN);
         done     <= (state == LD_RUN) && fin_s;
         err      <= len_we && (state != LD_IDLE);
         if ((state == LD_IDLE) && len_we) begin
            len_q <= len_in;
            wcnt  <= '0;
         end else if (wr) begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bitload_port_drv.sv
module bitload_port_drv #(
   parameter int DW          = 8,
   parameter int LEN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drain_async,
   input  logic [LEN_W-1:0] len_q,
   input  logic             empty,
   input  logic [DW-1:0]    rdata,
   input  logic             port_busy,
   output logic             rd,
   output logic             fin,
   output logic             en,
   output logic [DW-1:0]    data
);

   logic             drain_s;
   logic [LEN_W-1:0] cnt;

   bitload_sync #(.W(1), .STAGES(SYNC_STAGES)) u_drain (
      .clk(clk), .rst_n(rst_n), .d(drain_async), .q(drain_s));

   assign rd = drain_s && (cnt != len_q) && !empty && !port_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fin  <= 1'b0;
         en   <= 1'b0;
         data <= '0;
      end else begin
         en <= rd;
         if (rd) data <= rdata;
         if (!drain_s) begin
            cnt <= '0;
            fin <= 1'b0;
         end else begin
            if (rd) cnt <= cnt + 1'b1;
            fin <= (cnt == len_q);
         end
      end
   end

endmodule

// File: rtl/bitload_ctrl.sv
module bitload_ctrl #(
   parameter int DATA_W      = 8,
   parameter int LEN_W       = 16,
   parameter int BUF_AW      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              h_clk,
   input  logic              h_rst_n,
   input  logic              h_len_we,
   input  logic [LEN_W-1:0]  h_len,
   input  logic              h_in_active,
   input  logic              h_valid,
   input  logic [DATA_W-1:0] h_data,
   output logic              h_ready,
   output logic              h_busy,
   output logic              h_done,
   output logic              h_err,
   input  logic              c_clk,
   input  logic              c_rst_n,
   input  logic              cfg_busy,
   output logic              cfg_en,
   output logic              cfg_wr,
   output logic [DATA_W-1:0] cfg_data
);

   if (DATA_W < 1) begin : g_bad_dw
      $error("bitload_ctrl: DATA_W must be positive");
   end
   if (LEN_W < 2) begin : g_bad_lw
      $error("bitload_ctrl: LEN_W must be at least 2");
   end

   logic             fifo_wr, fifo_rd, fifo_full, fifo_empty;
   logic [DATA_W-1:0] fifo_rdata;
   logic             drain_en, fin;
   logic [LEN_W-1:0] len_q;
   logic             en_q;

   bitload_host_fsm #(.LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
      .clk(h_clk), .rst_n(h_rst_n), .len_we(h_len_we), .len_in(h_len),
      .in_active(h_in_active), .valid(h_valid), .full(fifo_full),
      .fin_async(fin), .ready(h_ready), .wr(fifo_wr), .busy(h_busy),
      .done(h_done), .err(h_err), .drain_en(drain_en), .len_q(len_q));

   bitload_fifo #(.DW(DATA_W), .AW(BUF_AW), .SYNC(SYNC_STAGES)) u_buf (
      .wclk(h_clk), .wrst_n(h_rst_n), .wr(fifo_wr), .wdata(h_data),
      .full(fifo_full), .rclk(c_clk), .rrst_n(c_rst_n), .rd(fifo_rd),
      .rdata(fifo_rdata), .empty(fifo_empty));

   bitload_port_drv #(.DW(DATA_W), .LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk(c_clk), .rst_n(c_rst_n), .drain_async(drain_en), .len_q(len_q),
      .empty(fifo_empty), .rdata(fifo_rdata), .port_busy(cfg_busy),
      .rd(fifo_rd), .fin(fin), .en(en_q), .data(cfg_data));

   assign cfg_en = en_q;
   assign cfg_wr = en_q;

endmodule

// File: rtl/bitload_ctrl_chk.sv
module bitload_ctrl_chk #(
   parameter int LEN_W = 16
) (
   input logic             h_clk,
   input logic             h_rst_n,
   input logic             c_clk,
   input logic             c_rst_n,
   input logic             h_len_we,
   input logic             h_busy,
   input logic             h_err,
   input logic             h_done,
   input logic             h_ready,
   input logic             fifo_wr,
   input logic             fifo_full,
   input logic             fifo_rd,
   input logic             fifo_empty,
   input logic [LEN_W-1:0] len_q,
   input logic             cfg_busy,
   input logic             cfg_en
);

   AST_NO_OVERFLOW: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      fifo_wr |-> !fifo_full); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge c_clk) disable iff (!c_rst_n)
      fifo_rd |-> !fifo_empty); // R3
   AST_BUSY_PAUSE: assert property (@(posedge c_clk) disable iff (!c_rst_n)
      cfg_busy |=> !cfg_en); // R6
   AST_ERR_ON_BUSY: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      (h_len_we && h_busy) |=> h_err); // R9
   AST_NO_SPURIOUS_ERR: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      !(h_len_we && h_busy) |=> !h_err); // R9
   AST_DONE_PULSE: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      h_done |=> !h_done); // R8
   AST_LEN_HELD: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      h_busy |=> (!h_busy || $stable(len_q))); // R9
   AST_IDLE_NO_READY: assert property (@(posedge h_clk) disable iff (!h_rst_n)
      !h_busy |-> !h_ready); // R2

endmodule

bind bitload_ctrl bitload_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
   .h_clk(h_clk), .h_rst_n(h_rst_n), .c_clk(c_clk), .c_rst_n(c_rst_n),
   .h_len_we(h_len_we), .h_busy(h_busy), .h_err(h_err), .h_done(h_done),
   .h_ready(h_ready), .fifo_wr(fifo_wr), .fifo_full(fifo_full),
   .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .len_q(len_q),
   .cfg_busy(cfg_busy), .cfg_en(cfg_en));

// File: tb/bitload_ctrl_test.sv
module bitload_ctrl_test;

   localparam int DW    = 8;
   localparam int LEN_W = 16;

   logic h_clk = 1'b0, c_clk = 1'b0;
   always #4  h_clk = ~h_clk;
   always #10 c_clk = ~c_clk;

   logic h_rst_n = 1'b0, c_rst_n = 1'b0;
   logic h_len_we = 1'b0, h_in_active = 1'b0, h_valid = 1'b0;
   logic [LEN_W-1:0] h_len = '0;
   logic [DW-1:0] h_data = '0;
   logic h_ready, h_busy, h_done, h_err;
   logic cfg_busy = 1'b0;
   logic cfg_en, cfg_wr;
   logic [DW-1:0] cfg_data;

   bitload_ctrl #(.DATA_W(DW), .LEN_W(LEN_W), .BUF_AW(4), .SYNC_STAGES(2)) uut (
      .h_clk(h_clk), .h_rst_n(h_rst_n), .h_len_we(h_len_we), .h_len(h_len),
      .h_in_active(h_in_active), .h_valid(h_valid), .h_data(h_data),
      .h_ready(h_ready), .h_busy(h_busy), .h_done(h_done), .h_err(h_err),
      .c_clk(c_clk), .c_rst_n(c_rst_n), .cfg_busy(cfg_busy),
      .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_data(cfg_data));

   int n_cmp = 0, n_bad = 0;
   logic [DW-1:0] exp_q [$];
   int  cur_len = 0, acc_cnt = 0, port_cnt = 0, done_cnt = 0, err_cnt = 0;
   bit  in_load = 0, released = 0, overlap_seen = 0, bp_seen = 0;
   bit  exp_err = 0, done_prev = 0, busy_prev_c = 0, live = 0;
   bit  busy_mode = 0;
   bit  finished = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // host-side reference model, compared every host clock
   always @(negedge h_clk) begin
      if (live) begin
         chk(h_err == exp_err, "R9 error pulse", h_err, exp_err);
         if (h_err) err_cnt++;
         exp_err = h_len_we && h_busy;
         if (in_load) chk(h_busy == 1'b1, "R2 busy during load", h_busy, 1);
         if (h_ready) chk(in_load && (acc_cnt < cur_len), "R2 ready window", acc_cnt, cur_len);
         chk(!(h_done && done_prev), "R8 done width", h_done, 0);
         done_prev = h_done;
         if (h_done) begin
            chk(in_load && (port_cnt == cur_len) && (exp_q.size() == 0),
                "R8 done after last byte", port_cnt, cur_len);
            done_cnt++;
            in_load  = 0;
            released = 0;
         end
         if (in_load && !h_in_active) released = 1;
         if (in_load && h_valid && !h_ready && (acc_cnt < cur_len)) bp_seen = 1;
         if (in_load && h_valid && h_ready) begin
            exp_q.push_back(h_data);
            acc_cnt++;
         end
         if (h_len_we && !h_busy) begin
            cur_len  = int'(h_len);
            acc_cnt  = 0;
            port_cnt = 0;
            in_load  = 1;
            released = !h_in_active;
         end
      end
   end

   // port-side reference model, compared every configuration clock
   always @(negedge c_clk) begin
      if (live) begin
         chk(cfg_wr == cfg_en, "R3 enable pairing", cfg_wr, cfg_en);
         if (busy_prev_c) chk(!cfg_en, "R6 pause after port busy", cfg_en, 0);
         if (cfg_en) begin
            chk(in_load && released, "R4 drain held during input transfer", released, 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 extra byte", cfg_data, -1);
            end else begin
               chk(cfg_data == exp_q[0], "R3 byte order", cfg_data, exp_q[0]);
               void'(exp_q.pop_front());
               port_cnt++;
            end
            if (acc_cnt < cur_len) overlap_seen = 1;
         end
         busy_prev_c = cfg_busy;
      end
   end

   int ccyc = 0;
   always @(posedge c_clk) begin
      #1;
      ccyc++;
      cfg_busy = busy_mode && (((ccyc % 5) == 2) || ((ccyc % 7) == 0));
   end

   task automatic run_load(int len, int hold, int seed, int gap);
      int d0;
      int t;
      d0 = done_cnt;
      @(posedge h_clk); #1;
      h_in_active = (hold > 0);
      h_len    = LEN_W'(len);
      h_len_we = 1'b1;
      @(posedge h_clk); #1;
      h_len_we = 1'b0;
      fork
         begin
            for (int i = 0; i < len; i++) begin
               bit took;
               took    = 0;
               h_valid = 1'b1;
               h_data  = 8'(seed * 31 + i * 7 + (i >> 3));
               while (!took) begin
                  @(negedge h_clk);
                  took = h_ready;
                  @(posedge h_clk); #1;
               end
               if (gap > 0) begin
                  h_valid = 1'b0;
                  repeat (gap) @(posedge h_clk);
                  #1;
               end
            end
            h_valid = 1'b0;
         end
         begin
            repeat (hold) @(posedge h_clk);
            #1;
            h_in_active = 1'b0;
         end
      join
      t = 0;
      while ((done_cnt == d0) && (t < 20000)) begin
         @(posedge h_clk);
         t++;
      end
      chk(done_cnt == d0 + 1, "R8 one done per load", done_cnt - d0, 1);
      chk(port_cnt == len, "R3 byte count", port_cnt, len);
      t = 0;
      while (h_busy && (t < 200)) begin
         @(posedge h_clk);
         t++;
      end
      #1;
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge c_clk);
      #1;
      h_rst_n = 1'b1;
      c_rst_n = 1'b1;
      @(negedge h_clk);
      // R1 reset state
      chk(!cfg_en && !cfg_wr, "R1 port enables after reset", cfg_en, 0);
      chk(!h_busy && !h_ready, "R1 idle after reset", h_busy, 0);
      chk(!h_done && !h_err, "R1 flags after reset", h_done, 0);
      live = 1;

      run_load(1, 0, 1, 0);                  // R1 R3 single byte
      run_load(5, 30, 2, 0);                 // R4 held drain
      chk(exp_q.size() == 0, "R4 all held bytes delivered", exp_q.size(), 0);

      busy_mode = 1;
      run_load(100, 0, 3, 0);                // R5 R6 R7
      chk(overlap_seen, "R5 writes overlap draining", overlap_seen, 1);
      chk(bp_seen, "R7 back-pressure at full buffer", bp_seen, 1);

      run_load(0, 0, 4, 0);                  // R10 empty image

      begin
         int e0;
         e0 = err_cnt;
         fork
            run_load(40, 60, 5, 0);          // R9 original load survives
            begin
               repeat (20) @(posedge h_clk);
               #1;
               h_len    = LEN_W'(7);
               h_len_we = 1'b1;
               @(posedge h_clk); #1;
               h_len_we = 1'b0;
            end
         join
         chk(err_cnt == e0 + 1, "R9 one error pulse", err_cnt - e0, 1);
      end

      busy_mode = 0;
      run_load(300, 200, 6, 1);              // R7 R10 long image
      chk(!h_busy && !h_ready, "R2 idle after load", h_busy, 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule